// File: doc/BRIEF.md
# SPI Word/Byte Packer with Selectable Byte Order

This block sits between a 32-bit data path and the byte-wide port of an SPI shift engine. In the transmit direction it takes one word with four byte-lane enables and hands the enabled bytes, one per handshake, to the shifter. In the receive direction it gathers bytes from the shifter and assembles them into 32-bit words for a receive queue. A static parameter decides whether the most or the least significant lane goes first. The order of bits inside a byte is never changed. The shifter always sends bit 7 of each byte first.

The transmit side skips lanes that are not enabled and leaves no gap for them. A word with no enabled lane is consumed and produces no byte. Instead it raises a one-cycle access error. The receive side only delivers whole words. When the shifter marks a byte as the last of a segment, the partly filled word is pushed out, and the lanes that were never written read as zero. Both sides use valid/ready handshakes. Each side holds its upstream partner off while it still has data that the downstream partner has not taken.

Top module: `spi_word_packer`

## Requirements
- R1: With byte order 0, the enabled lanes of a transmit word leave from the highest lane to the lowest. Lane 3 is bits 31:24 and lane 0 is bits 7:0.
- R2: With byte order 1, the enabled lanes leave from the lowest lane to the highest.
- R3: Each transmitted or received byte is carried bit for bit. Bit 7 of a lane is bit 7 of the stream byte, and the reverse holds as well.
- R4: A transmit word yields exactly as many stream bytes as it has set enables, in back-to-back order with no gap for disabled lanes. The word ready stays low until the last of those bytes is taken.
- R5: A transmit word with enable value 4'b0000 is accepted and produces no stream byte. The access-error output is high for exactly the one cycle after its acceptance.
- R6: On receive, the first byte of a word lands in bits 31:24 when the byte order is 0. It lands in bits 7:0 when the byte order is 1. Later bytes fill the following lanes in the same direction.
- R7: A receive word is presented after four bytes, or earlier when a byte marked last is accepted. Lanes that were not filled read as zero.
- R8: While an output is valid and not yet taken, its valid stays high and its data stays stable. The receive byte ready is low while a word waits.
- R9: The byte-order output always equals the byte-order parameter.
- R10: After a synchronous reset, no output is valid, both ready outputs are high and the error output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_word_data | input | 32 | Transmit word |
| tx_word_be | input | 4 | Per-lane enables of the transmit word |
| tx_word_valid | input | 1 | Transmit word offered |
| tx_word_ready | output | 1 | Transmit word can be taken |
| tx_byte_data | output | 8 | Byte to the shifter |
| tx_byte_valid | output | 1 | Byte to the shifter is valid |
| tx_byte_ready | input | 1 | Shifter takes the byte |
| rx_byte_data | input | 8 | Byte from the shifter |
| rx_byte_valid | input | 1 | Byte from the shifter offered |
| rx_byte_last | input | 1 | Byte ends the segment |
| rx_byte_ready | output | 1 | Byte from the shifter can be taken |
| rx_word_data | output | 32 | Packed receive word |
| rx_word_valid | output | 1 | Receive word is valid |
| rx_word_ready | input | 1 | Receive queue takes the word |
| err_access | output | 1 | One-cycle pulse for a word with no enabled lane |
| byte_order | output | 1 | Byte-order setting, read only |

## Verification
Both byte orders are exercised side by side on the same transmit words. A word with a distinct value in every lane makes any lane swap or reversal visible. Sparse enable patterns such as 1010, 0110, 0001 and 1000 separate correct gap skipping from a lane counter that does not skip. The zero-enable word separates the error pulse from a silent drop. On the receive side, segments of one, two, three, four and eight bytes separate flushing on last, with zero fill, from filling on count alone. Random backpressure on both downstream readies shows that data is held when it is not taken.

// File: rtl/spi_pack_pkg.sv
package spi_pack_pkg;

  // Lane visited at position "step" of the serial order.
  // order = 0: top lane first; order = 1: bottom lane first.
  function automatic int lane_for_step(input int step, input int lanes, input bit order);
    return order ? step : (lanes - 1 - step);
  endfunction

endpackage

// File: rtl/spi_tx_unpacker.sv
module spi_tx_unpacker
  import spi_pack_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  parameter bit ORDER  = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [BYTE_W*LANES-1:0]   word_data,
  input  logic [LANES-1:0]          word_be,
  input  logic                      word_valid,
  output logic                      word_ready,
  output logic [BYTE_W-1:0]         byte_data,
  output logic                      byte_valid,
  input  logic                      byte_ready,
  output logic                      err_zero
);

  localparam int WORD_W = BYTE_W * LANES;

  logic [WORD_W-1:0]              word_q;
  logic [LANES-1:0]               mask_q;
  logic                           err_q;
  logic [LANES-1:0]               mask_ord;
  logic [LANES-1:0]               first_ord;
  logic [LANES-1:0]               clear_lane;
  logic [LANES-1:0][BYTE_W-1:0]   word_ord;

  // Put the lanes into serial order so that the lowest set bit is next.
  for (genvar s = 0; s < LANES; s++) begin : g_ord
    localparam int L = lane_for_step(s, LANES, ORDER);
    assign mask_ord[s]   = mask_q[L];
    assign word_ord[s]   = word_q[L*BYTE_W +: BYTE_W];
    assign clear_lane[L] = first_ord[s];
  end

  // Isolate the earliest pending lane.
  assign first_ord = mask_ord & (~mask_ord + 1'b1);

  always_comb begin
    byte_data = '0;
    for (int s = 0; s < LANES; s++) begin
      if (first_ord[s]) byte_data = byte_data | word_ord[s];
    end
  end

  assign word_ready = (mask_q == '0);
  assign byte_valid = (mask_q != '0);
  assign err_zero   = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (word_valid && word_ready) begin
        word_q <= word_data;
        mask_q <= word_be;
        err_q  <= (word_be == '0);
      end else if (byte_valid && byte_ready) begin
        mask_q <= mask_q & ~clear_lane;
      end
    end
  end

endmodule

// File: rtl/spi_rx_packer.sv
module spi_rx_packer
  import spi_pack_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  parameter bit ORDER  = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [BYTE_W-1:0]         byte_data,
  input  logic                      byte_valid,
  input  logic                      byte_last,
  output logic                      byte_ready,
  output logic [BYTE_W*LANES-1:0]   word_data,
  output logic                      word_valid,
  input  logic                      word_ready
);

  localparam int WORD_W = BYTE_W * LANES;
  localparam int CNT_W  = (LANES > 1) ? $clog2(LANES) : 1;

  logic [WORD_W-1:0] acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full_q;
  logic [LANES-1:0]  slot;

  // One-hot lane that the next byte fills.
  for (genvar s = 0; s < LANES; s++) begin : g_slot
    localparam int L = lane_for_step(s, LANES, ORDER);
    assign slot[L] = (cnt_q == CNT_W'(s));
  end

  assign byte_ready = !full_q;
  assign word_valid = full_q;
  assign word_data  = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (full_q) begin
      if (word_ready) begin
        acc_q  <= '0;
        cnt_q  <= '0;
        full_q <= 1'b0;
      end
    end else if (byte_valid) begin
      for (int l = 0; l < LANES; l++) begin
        if (slot[l]) acc_q[l*BYTE_W +: BYTE_W] <= byte_data;
      end
      cnt_q <= cnt_q + 1'b1;
      if (byte_last || cnt_q == CNT_W'(LANES - 1)) full_q <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_word_packer.sv
module spi_word_packer #(
  parameter bit BYTE_ORDER = 1'b0,
  parameter int BYTE_W     = 8,
  parameter int LANES      = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [BYTE_W*LANES-1:0]  tx_word_data,
  input  logic [LANES-1:0]         tx_word_be,
  input  logic                     tx_word_valid,
  output logic                     tx_word_ready,
  output logic [BYTE_W-1:0]        tx_byte_data,
  output logic                     tx_byte_valid,
  input  logic                     tx_byte_ready,
  input  logic [BYTE_W-1:0]        rx_byte_data,
  input  logic                     rx_byte_valid,
  input  logic                     rx_byte_last,
  output logic                     rx_byte_ready,
  output logic [BYTE_W*LANES-1:0]  rx_word_data,
  output logic                     rx_word_valid,
  input  logic                     rx_word_ready,
  output logic                     err_access,
  output logic                     byte_order
);

  spi_tx_unpacker #(.BYTE_W(BYTE_W), .LANES(LANES), .ORDER(BYTE_ORDER)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .word_data  (tx_word_data),
    .word_be    (tx_word_be),
    .word_valid (tx_word_valid),
    .word_ready (tx_word_ready),
    .byte_data  (tx_byte_data),
    .byte_valid (tx_byte_valid),
    .byte_ready (tx_byte_ready),
    .err_zero   (err_access)
  );

  spi_rx_packer #(.BYTE_W(BYTE_W), .LANES(LANES), .ORDER(BYTE_ORDER)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .byte_data  (rx_byte_data),
    .byte_valid (rx_byte_valid),
    .byte_last  (rx_byte_last),
    .byte_ready (rx_byte_ready),
    .word_data  (rx_word_data),
    .word_valid (rx_word_valid),
    .word_ready (rx_word_ready)
  );

  assign byte_order = BYTE_ORDER;

endmodule

// File: rtl/spi_word_packer_chk.sv
module spi_word_packer_chk #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic [LANES-1:0]         tx_word_be,
  input logic                     tx_word_valid,
  input logic                     tx_word_ready,
  input logic [BYTE_W-1:0]        tx_byte_data,
  input logic                     tx_byte_valid,
  input logic                     tx_byte_ready,
  input logic                     rx_byte_valid,
  input logic                     rx_byte_last,
  input logic                     rx_byte_ready,
  input logic [BYTE_W*LANES-1:0]  rx_word_data,
  input logic                     rx_word_valid,
  input logic                     rx_word_ready,
  input logic                     err_access
);

  // R4
  tx_load_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_word_valid && tx_word_ready && tx_word_be != '0) |=> (tx_byte_valid && !tx_word_ready));

  // R5
  zero_be_err_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_word_valid && tx_word_ready && tx_word_be == '0) |=> (err_access && !tx_byte_valid));

  // R5
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    err_access |-> $past(tx_word_valid && tx_word_ready && tx_word_be == '0));

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_byte_valid && !tx_byte_ready) |=> (tx_byte_valid && $stable(tx_byte_data)));

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_word_valid && !rx_word_ready) |=> (rx_word_valid && $stable(rx_word_data)));

  // R8
  rx_stall_chk: assert property (@(posedge clk) disable iff (rst)
    rx_word_valid |-> !rx_byte_ready);

  // R7
  rx_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_byte_valid && rx_byte_ready && rx_byte_last) |=> rx_word_valid);

endmodule

bind spi_word_packer spi_word_packer_chk #(.BYTE_W(BYTE_W), .LANES(LANES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .tx_word_be    (tx_word_be),
  .tx_word_valid (tx_word_valid),
  .tx_word_ready (tx_word_ready),
  .tx_byte_data  (tx_byte_data),
  .tx_byte_valid (tx_byte_valid),
  .tx_byte_ready (tx_byte_ready),
  .rx_byte_valid (rx_byte_valid),
  .rx_byte_last  (rx_byte_last),
  .rx_byte_ready (rx_byte_ready),
  .rx_word_data  (rx_word_data),
  .rx_word_valid (rx_word_valid),
  .rx_word_ready (rx_word_ready),
  .err_access    (err_access)
);

// File: tb/tb_lane.sv
module tb_lane #(
  parameter bit ORDER = 1'b0
) (
  input  logic clk,
  input  logic rst,
  output int   errs,
  output int   chks,
  output logic done
);

  localparam logic [31:0] TXW [7] = '{32'hA1B2C3D4, 32'h11223344, 32'h55667788, 32'h99AABBCC,
                                      32'hDEADBEEF, 32'h01020304, 32'hF00DCAFE};
  localparam logic [3:0]  TXB [7] = '{4'b1111, 4'b1010, 4'b0001, 4'b0000, 4'b1000, 4'b0110, 4'b1111};

  logic [31:0] tw_data;
  logic [3:0]  tw_be;
  logic        tw_valid, tb_ready;
  logic [7:0]  rb_data;
  logic        rb_valid, rb_last, rw_ready;
  logic [7:0]  tx_byte_data;
  logic        tx_word_ready, tx_byte_valid, rx_byte_ready, rx_word_valid, err_access, byte_order;
  logic [31:0] rx_word_data;

  spi_word_packer #(.BYTE_ORDER(ORDER)) dut (
    .clk(clk), .rst(rst),
    .tx_word_data(tw_data), .tx_word_be(tw_be), .tx_word_valid(tw_valid), .tx_word_ready(tx_word_ready),
    .tx_byte_data(tx_byte_data), .tx_byte_valid(tx_byte_valid), .tx_byte_ready(tb_ready),
    .rx_byte_data(rb_data), .rx_byte_valid(rb_valid), .rx_byte_last(rb_last), .rx_byte_ready(rx_byte_ready),
    .rx_word_data(rx_word_data), .rx_word_valid(rx_word_valid), .rx_word_ready(rw_ready),
    .err_access(err_access), .byte_order(byte_order)
  );

  // Reference model state
  logic [7:0]  pend[$];
  logic [31:0] macc;
  int          mcnt;
  bit          mfull, merr;
  int          n_bytes, n_words, n_err;
  logic [7:0]  first_byte;
  logic [31:0] first_word;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s order=%0d actual=%h expected=%h", req, ORDER, act, exp);
    end
  endtask

  initial begin
    errs = 0; chks = 0;
  end

  always @(posedge clk) begin
    if (rst) begin
      pend.delete(); macc = '0; mcnt = 0; mfull = 0; merr = 0;
      n_bytes = 0; n_words = 0; n_err = 0;
    end else begin
      merr = 0;
      if (tx_byte_valid && tb_ready && pend.size() > 0) begin
        if (n_bytes == 0) first_byte = pend[0];
        void'(pend.pop_front());
        n_bytes++;
      end
      if (tw_valid && tx_word_ready) begin
        if (tw_be == 4'b0000) merr = 1;
        for (int k = 0; k < 4; k++) begin
          int ln;
          ln = ORDER ? k : 3 - k;
          if (tw_be[ln]) pend.push_back(tw_data[ln*8 +: 8]);
        end
      end
      if (mfull) begin
        if (rw_ready) begin
          if (n_words == 0) first_word = macc;
          n_words++; mfull = 0; macc = '0; mcnt = 0;
        end
      end else if (rb_valid) begin
        int ln;
        ln = ORDER ? mcnt : 3 - mcnt;
        macc[ln*8 +: 8] = rb_data;
        mcnt++;
        if (mcnt == 4 || rb_last) mfull = 1;
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      // R10
      check(!tx_byte_valid && tx_word_ready && !rx_word_valid && rx_byte_ready && !err_access,
            "R10 reset state", {27'd0, tx_byte_valid, tx_word_ready, rx_word_valid, rx_byte_ready, err_access},
            32'h0000000A);
    end else begin
      // R4 / R8
      check(tx_byte_valid == (pend.size() > 0), "R4 tx byte valid", 32'(tx_byte_valid), 32'(pend.size() > 0));
      check(tx_word_ready == (pend.size() == 0), "R4 tx word ready", 32'(tx_word_ready), 32'(pend.size() == 0));
      // R1 / R2 / R3
      if (pend.size() > 0)
        check(tx_byte_data == pend[0], ORDER ? "R2 R3 tx byte" : "R1 R3 tx byte", 32'(tx_byte_data), 32'(pend[0]));
      // R7 / R8
      check(rx_word_valid == mfull, "R7 rx word valid", 32'(rx_word_valid), 32'(mfull));
      check(rx_byte_ready == !mfull, "R8 rx byte ready", 32'(rx_byte_ready), 32'(!mfull));
      // R6 / R7
      if (mfull) check(rx_word_data == macc, "R6 R7 rx word", rx_word_data, macc);
      // R5
      check(err_access == merr, "R5 access error", 32'(err_access), 32'(merr));
      if (err_access) n_err++;
      // R9
      check(byte_order == ORDER, "R9 byte order", 32'(byte_order), 32'(ORDER));
    end
  end

  // Downstream backpressure
  initial begin
    logic [15:0] lfsr;
    lfsr = ORDER ? 16'hACE1 : 16'h1D2B;
    tb_ready = 0; rw_ready = 0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tb_ready = lfsr[0] | lfsr[3];
      rw_ready = lfsr[5] | lfsr[7];
    end
  end

  initial begin
    tw_valid = 0; tw_data = '0; tw_be = '0;
    rb_valid = 0; rb_data = '0; rb_last = 0; done = 0;
    @(negedge clk);
    while (rst) @(negedge clk);
    fork
      begin
        for (int i = 0; i < 7; i++) begin
          tw_data = TXW[i]; tw_be = TXB[i]; tw_valid = 1;
          while (!tx_word_ready) @(negedge clk);
          @(negedge clk);
          tw_valid = 0;
        end
      end
      begin
        for (int i = 0; i < 18; i++) begin
          rb_data = 8'h10 + 8'(i * 7); rb_valid = 1;
          rb_last = (i == 5 || i == 6 || i == 9 || i == 17);
          while (!rx_byte_ready) @(negedge clk);
          @(negedge clk);
          rb_valid = 0; rb_last = 0;
        end
      end
    join
    repeat (60) @(negedge clk);
    // R4: 4+2+1+0+1+2+4 enabled lanes in total
    check(n_bytes == 14, "R4 byte count", 32'(n_bytes), 32'd14);
    // R5: one zero-enable word
    check(n_err == 1, "R5 error pulses", 32'(n_err), 32'd1);
    // R7: segments of 4+2, 1, 3, 8 bytes give 6 words
    check(n_words == 6, "R7 word count", 32'(n_words), 32'd6);
    // R1 / R2: first byte of A1B2C3D4
    check(first_byte == (ORDER ? 8'hD4 : 8'hA1), ORDER ? "R2 first byte" : "R1 first byte",
          32'(first_byte), ORDER ? 32'hD4 : 32'hA1);
    // R6: bytes 10,17,1E,25
    check(first_word == (ORDER ? 32'h251E1710 : 32'h10171E25), "R6 first word",
          first_word, ORDER ? 32'h251E1710 : 32'h10171E25);
    done = 1;
  end

endmodule

// File: tb/tb_spi_word_packer.sv
module tb_spi_word_packer;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   errs_be, chks_be, errs_le, chks_le;
  logic done_be, done_le;
  int   wd_fail = 0;

  always #4 clk = ~clk;

  tb_lane #(.ORDER(1'b0)) u_be (.clk(clk), .rst(rst), .errs(errs_be), .chks(chks_be), .done(done_be));
  tb_lane #(.ORDER(1'b1)) u_le (.clk(clk), .rst(rst), .errs(errs_le), .chks(chks_le), .done(done_le));

  initial begin
    int cyc;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    while (!(done_be === 1'b1 && done_le === 1'b1) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 20000) begin
      wd_fail = 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errs_be + errs_le + wd_fail, chks_be + chks_le + 1);
    $finish;
  end

endmodule